// File: doc/BRIEF.md
# SMBus Packet Error Code Engine

This block keeps a running CRC-8 over an SMBus transaction while the bus engine moves bytes across the wire. A start strobe opens a new transaction and sets the running value back to its initial value. After that, every byte the engine marks valid is folded into the code in one clock. The folded bytes include the address byte with its read/write bit, and any address byte that follows a repeated start. The running code is always visible, so a transmitter can take the byte to append as the final byte of its transfer.

In check mode, the received PEC byte is fed through the same arithmetic. For an intact packet the code then comes to a residue of zero. Any other residue raises an error flag, and a one-cycle done pulse marks the verdict. The I2C bit shifting and acknowledge handling live in the bus engine, outside this block.

Top module: `smb_pec_engine`

## Requirements
- R1: While reset is held and in the first cycles after it, `pec_byte` reads 0x00 and both `chk_done` and `chk_err` read 0.
- R2: The code is a CRC-8 with polynomial x^8+x^2+x+1 (0x07), taken MSB first with no reflection and no final XOR. The nine ASCII bytes "123456789" give 0xF4.
- R3: Each cycle with `byte_vld` high folds `byte_in` into the code, and the result appears on `pec_byte` one clock later.
- R4: A `txn_start` cycle with `byte_vld` low sets `pec_byte` to 0x00 one clock later. When `byte_vld` is also high in that cycle, the byte is folded into 0x00, so that byte opens the transaction.
- R5: Only `txn_start` clears the code. A further address byte within the same transaction, such as after a repeated start, is folded in like any other byte.
- R6: In cycles with neither `byte_vld` nor `txn_start`, `pec_byte` holds its value.
- R7: A byte with `byte_vld`, `byte_last` and `chk_mode` all high produces a one-cycle `chk_done` pulse one clock later. With `chk_mode` low, `byte_last` produces no pulse and leaves `chk_err` unchanged.
- R8: The check verdict follows the residue. `chk_err` is 0 when the code after the final byte is 0x00 and 1 otherwise. It holds until the next verdict, or until a `txn_start` that carries no checked last byte clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| txn_start | input | 1 | Opens a transaction; clears the running code |
| byte_vld | input | 1 | `byte_in` carries a message byte this cycle |
| byte_last | input | 1 | The valid byte is the final (PEC) byte |
| chk_mode | input | 1 | 1 = check a received PEC, 0 = generate |
| byte_in | input | 8 | Message byte |
| pec_byte | output | 8 | Running code; the byte to append in generate mode |
| chk_done | output | 1 | One-cycle pulse when a check verdict is ready |
| chk_err | output | 1 | Check verdict: 1 = residue not zero |

## Verification
The bench uses the default parameters: polynomial 0x07, a zero initial value and 8-bit bytes. These settings make the standard check value for "123456789" and the zero-residue property of an appended code directly observable. Single-byte vectors are chosen to pin down individual columns of the update, including the top bit and an all-ones byte. Multi-byte vectors cover code-plus-residue sequences, continuation without a start, and a start that coincides with a valid byte.

// File: rtl/smb_pec_pkg.sv
package smb_pec_pkg;
  parameter int unsigned CRC_W  = 8;
  parameter int unsigned BYTE_W = 8;

  typedef logic [CRC_W-1:0]  crc_t;
  typedef logic [BYTE_W-1:0] byte_t;

  // Parallel update: one byte folded MSB first into the code.
  function automatic crc_t crc_fold(input crc_t cur, input byte_t din, input crc_t poly);
    crc_t acc;
    logic fb;
    acc = cur;
    for (int i = BYTE_W - 1; i >= 0; i--) begin
      fb  = acc[CRC_W-1] ^ din[i];
      acc = {acc[CRC_W-2:0], 1'b0};
      if (fb) acc = acc ^ poly;
    end
    return acc;
  endfunction
endpackage

// File: rtl/smb_pec_rst_sync.sv
module smb_pec_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb sh_d = {sh_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_n_sync = sh_q[STAGES-1];
endmodule

// File: rtl/smb_pec_core.sv
module smb_pec_core
  import smb_pec_pkg::*;
#(
  parameter crc_t POLY = 8'h07,
  parameter crc_t INIT = 8'h00
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  txn_start,
  input  logic  byte_vld,
  input  byte_t byte_in,
  output crc_t  crc_q,
  output crc_t  crc_nxt
);
  crc_t base;
  logic upd_en;

  always_comb begin
    base    = txn_start ? INIT : crc_q;
    crc_nxt = byte_vld ? crc_fold(base, byte_in, POLY) : base;
    upd_en  = txn_start | byte_vld;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      crc_q <= INIT;
    else if (upd_en) crc_q <= crc_nxt;
  end
endmodule

// File: rtl/smb_pec_verdict.sv
module smb_pec_verdict
  import smb_pec_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic txn_start,
  input  logic take,
  input  crc_t residue,
  output logic done_q,
  output logic err_q
);
  logic done_d;
  logic err_d;

  always_comb begin
    done_d = take;
    err_d  = err_q;
    if (take)           err_d = (residue != '0);
    else if (txn_start) err_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= done_d;
      err_q  <= err_d;
    end
  end
endmodule

// File: rtl/smb_pec_engine.sv
module smb_pec_engine
  import smb_pec_pkg::*;
#(
  parameter crc_t        POLY       = 8'h07,
  parameter crc_t        INIT       = 8'h00,
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              txn_start,
  input  logic              byte_vld,
  input  logic              byte_last,
  input  logic              chk_mode,
  input  logic [BYTE_W-1:0] byte_in,
  output logic [CRC_W-1:0]  pec_byte,
  output logic              chk_done,
  output logic              chk_err
);
  logic rst_n_int;
  crc_t crc_q;
  crc_t crc_nxt;
  logic take;

  smb_pec_rst_sync #(.STAGES(SYNC_DEPTH)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  smb_pec_core #(.POLY(POLY), .INIT(INIT)) u_core (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .txn_start (txn_start),
    .byte_vld  (byte_vld),
    .byte_in   (byte_in),
    .crc_q     (crc_q),
    .crc_nxt   (crc_nxt)
  );

  assign take = byte_vld & byte_last & chk_mode;

  smb_pec_verdict u_verdict (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .txn_start (txn_start),
    .take      (take),
    .residue   (crc_nxt),
    .done_q    (chk_done),
    .err_q     (chk_err)
  );

  assign pec_byte = crc_q;
endmodule

// File: rtl/smb_pec_engine_chk.sv
module smb_pec_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       txn_start,
  input logic       byte_vld,
  input logic       byte_last,
  input logic       chk_mode,
  input logic [7:0] pec_byte,
  input logic       chk_done,
  input logic       chk_err
);
  // R6
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!byte_vld && !txn_start) |=> $stable(pec_byte));

  // R4
  start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_start && !byte_vld) |=> (pec_byte == 8'h00));

  // R7
  done_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_done |-> $past(byte_vld && byte_last && chk_mode));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && byte_last && chk_mode) |=> chk_done);

  // R8
  verdict_residue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_done |-> (chk_err == (pec_byte != 8'h00)));

  // R8
  err_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chk_err) |-> chk_done);
endmodule

bind smb_pec_engine smb_pec_engine_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .txn_start (txn_start),
  .byte_vld  (byte_vld),
  .byte_last (byte_last),
  .chk_mode  (chk_mode),
  .pec_byte  (pec_byte),
  .chk_done  (chk_done),
  .chk_err   (chk_err)
);

// File: tb/tb_smb_pec_engine.sv
module tb_smb_pec_engine;
  logic       clk;
  logic       rst_n;
  logic       txn_start;
  logic       byte_vld;
  logic       byte_last;
  logic       chk_mode;
  logic [7:0] byte_in;
  logic [7:0] pec_byte;
  logic       chk_done;
  logic       chk_err;

  int checks;
  int errors;

  smb_pec_engine dut (
    .clk(clk), .rst_n(rst_n), .txn_start(txn_start), .byte_vld(byte_vld),
    .byte_last(byte_last), .chk_mode(chk_mode), .byte_in(byte_in),
    .pec_byte(pec_byte), .chk_done(chk_done), .chk_err(chk_err)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // {length, b0, b1, b2, expected code}
  localparam logic [7:0] VEC [8][5] = '{
    '{8'd1, 8'h00, 8'h00, 8'h00, 8'h00},
    '{8'd1, 8'h01, 8'h00, 8'h00, 8'h07},
    '{8'd1, 8'h80, 8'h00, 8'h00, 8'h89},
    '{8'd1, 8'hFF, 8'h00, 8'h00, 8'hF3},
    '{8'd2, 8'h01, 8'h07, 8'h00, 8'h00},
    '{8'd2, 8'h80, 8'h89, 8'h00, 8'h00},
    '{8'd2, 8'h01, 8'h00, 8'h00, 8'h15},
    '{8'd3, 8'hFF, 8'hF3, 8'h00, 8'h00}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // drives one cycle at a negedge, returns at the following negedge
  task automatic drive(input logic st, input logic vld, input logic lst,
                       input logic md, input logic [7:0] b);
    @(negedge clk);
    txn_start = st; byte_vld = vld; byte_last = lst; chk_mode = md; byte_in = b;
    @(negedge clk);
    txn_start = 1'b0; byte_vld = 1'b0; byte_last = 1'b0; byte_in = 8'h00;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] msg [9];
    checks = 0; errors = 0;
    rst_n = 1'b0; txn_start = 1'b0; byte_vld = 1'b0; byte_last = 1'b0;
    chk_mode = 1'b0; byte_in = 8'h00;
    repeat (3) @(negedge clk);
    check("R1 reset pec_byte", pec_byte, 8'h00);
    check("R1 reset chk_done", {7'd0, chk_done}, 8'h00);
    check("R1 reset chk_err", {7'd0, chk_err}, 8'h00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release", pec_byte, 8'h00);

    // vector table, R3
    for (int v = 0; v < 8; v++) begin
      for (int k = 0; k < int'(VEC[v][0]); k++)
        drive(k == 0, 1'b1, 1'b0, 1'b0, VEC[v][k+1]);
      check($sformatf("R3 vector %0d", v), pec_byte, VEC[v][4]);
    end

    // R2: standard check string
    for (int k = 0; k < 9; k++) msg[k] = 8'h31 + 8'(k);
    for (int k = 0; k < 9; k++) drive(k == 0, 1'b1, 1'b0, 1'b0, msg[k]);
    check("R2 123456789", pec_byte, 8'hF4);

    // R4: start alone clears
    drive(1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
    check("R4 start clears", pec_byte, 8'h00);

    // R5: no start -> continues; 01 then 00 gives 15
    drive(1'b1, 1'b1, 1'b0, 1'b0, 8'h01);
    drive(1'b0, 1'b1, 1'b0, 1'b0, 8'h00);
    check("R5 repeated-start byte folds in", pec_byte, 8'h15);

    // R4: start with byte discards old state
    drive(1'b1, 1'b1, 1'b0, 1'b0, 8'h01);
    check("R4 start with byte", pec_byte, 8'h07);

    // R6: idle cycles hold
    repeat (3) @(negedge clk);
    check("R6 hold", pec_byte, 8'h07);

    // R7: generate-mode last byte gives no pulse
    drive(1'b0, 1'b1, 1'b1, 1'b0, 8'h07);
    check("R7 no pulse in generate", {7'd0, chk_done}, 8'h00);
    check("R7 err unchanged in generate", {7'd0, chk_err}, 8'h00);

    // R8: good packet "123456789" + F4
    for (int k = 0; k < 9; k++) drive(k == 0, 1'b1, 1'b0, 1'b1, msg[k]);
    @(negedge clk);
    txn_start = 1'b0; byte_vld = 1'b1; byte_last = 1'b1; chk_mode = 1'b1; byte_in = 8'hF4;
    @(negedge clk);
    byte_vld = 1'b0; byte_last = 1'b0;
    check("R7 done pulse", {7'd0, chk_done}, 8'h01);
    check("R8 good residue", {7'd0, chk_err}, 8'h00);
    @(negedge clk);
    check("R7 pulse one cycle", {7'd0, chk_done}, 8'h00);

    // R8: bad packet, PEC F5
    for (int k = 0; k < 9; k++) drive(k == 0, 1'b1, 1'b0, 1'b1, msg[k]);
    drive(1'b0, 1'b1, 1'b1, 1'b1, 8'hF5);
    check("R8 bad residue flags", {7'd0, chk_err}, 8'h01);
    repeat (2) @(negedge clk);
    check("R8 err held", {7'd0, chk_err}, 8'h01);
    drive(1'b0, 1'b1, 1'b1, 1'b0, 8'h00);
    check("R7 generate last leaves err", {7'd0, chk_err}, 8'h01);
    drive(1'b1, 1'b0, 1'b0, 1'b1, 8'h00);
    check("R8 start clears err", {7'd0, chk_err}, 8'h00);

    // R8: address byte with R/W, data, PEC: 80 then 89 -> good
    drive(1'b1, 1'b1, 1'b0, 1'b1, 8'h80);
    drive(1'b0, 1'b1, 1'b1, 1'b1, 8'h89);
    check("R8 short packet good", {7'd0, chk_err}, 8'h00);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule